// File: doc/BRIEF.md
# ACPI Sleep-State Control Sequencer

This block decides the power state of a board-level supply arrangement from two active-low sleep request lines and two supply-quality inputs. The first request line asks to leave the running state. The second, read when that request is acted on, picks deep sleep over suspend-to-RAM. A main-rail power-good input and an active-low bias power-on reset complete the inputs. The block settles on one of four states: pending (waiting for the main rail to settle), active, suspend sleep, or deep sleep. From that state it drives the digital enables for the active-path switches, the VID regulator, and the two sleep-path dual-rail feeds.

Both request lines are synchronised and then deglitched by a stable-count filter. A sleep request is acted on only after it has been held for a fixed interval. An input pair that would move suspend sleep straight to deep sleep, or back, is ignored. So is the combination that is not allowed. Wake-up always passes through the pending state, which holds the active path off until the main rail has been good for a fixed timeout. If the main rail drops while active, the block is forced into deep sleep and raises an undervoltage flag. It stays there until the rail returns. An external shutdown request turns every enable off and restarts the sequence.

Top module: `acpi_sleep_seq`

## Requirements
- R1: A change on a request line reaches the state logic only after the synchronised level has differed from the filtered level for FILT_CYC consecutive cycles. A pulse shorter than that has no effect on the state.
- R2: The filtered input pair (deep-sleep line low, suspend line high) is not allowed. It never changes the state, whatever the current state is.
- R3: In pending or active, a filtered suspend line held low for ENTRY_CYC cycles moves the state to suspend sleep (code 2) if the deep-sleep line is high, or to deep sleep (code 3) if it is low. If the suspend line returns high before then, the timer is cancelled and the state is kept.
- R4: The state never moves directly from suspend sleep to deep sleep, nor from deep sleep to suspend sleep.
- R5: From either sleep state, both filtered lines high move the state to pending (code 0). Pending moves to active (code 1) after main_pg and both lines have been high for WAKE_CYC consecutive cycles.
- R6: act_sw_en and vid_en are high only in the active state, and only while no shutdown is requested.
- R7: dual5_sb_en is high in suspend sleep, follows dual5_keep in deep sleep, and is low in pending and active. dual3_sb_en is high in every state except active.
- R8: Loss of main_pg while active moves the state to deep sleep in the next cycle and sets uv_fault. The state stays in deep sleep whatever the request lines do until main_pg returns. When it returns, uv_fault clears.
- R9: While shdn_req is high, every enable is low. The state is reset to pending, uv_fault is cleared, and both timers restart.
- R10: While por_n is low, the state is pending, both filtered lines are taken as high, uv_fault is low and only dual3_sb_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Bias power-on reset, active low, asynchronous |
| slp3_n | input | 1 | Suspend request, active low, asynchronous |
| slp5_n | input | 1 | Deep-sleep select, active low, asynchronous |
| main_pg | input | 1 | Main 3.3 V rail above its threshold |
| shdn_req | input | 1 | External shutdown request, synchronous |
| dual5_keep | input | 1 | Keeps the 5 V dual feed on in deep sleep |
| act_sw_en | output | 1 | Active-path switch enable |
| vid_en | output | 1 | VID regulator enable |
| dual5_sb_en | output | 1 | Sleep-path feed enable for the 5 V dual rail |
| dual3_sb_en | output | 1 | Sleep-path regulation enable for the 3.3 V dual rail |
| pwr_state | output | 2 | 0 pending, 1 active, 2 suspend sleep, 3 deep sleep |
| uv_fault | output | 1 | Main-rail undervoltage seen while active |

## Verification
The embedded assertions check, on every cycle, that no jump between the two sleep states occurs. They also check that each entry into active is preceded by an expired wake timer and each ordinary entry into sleep by an expired entry timer. Further checks cover the response to main-rail loss within one cycle, the fault flag only ever coinciding with deep sleep, and a filtered line changing only to the synchronised level. The exact cycle counts of the filter and both timers, glitch rejection, cancellation of a sleep request, the hold on the forbidden pair and the effect of dual5_keep show up only in the bench's scenarios. There, a behavioural model is compared with the outputs every clock.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    PS_PEND = 2'd0,
    PS_ACT  = 2'd1,
    PS_S3   = 2'd2,
    PS_S45  = 2'd3
  } pstate_t;

  // Sleep state chosen when the entry interval expires.
  function automatic pstate_t sleep_target(input logic deep_n);
    return deep_n ? PS_S3 : PS_S45;
  endfunction

  // True on the last cycle of an interval of lim cycles.
  function automatic logic last_tick(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  // Sleep-path 5 V dual feed for a given state.
  function automatic logic dual5_on(input pstate_t st, input logic keep);
    return (st == PS_S3) || ((st == PS_S45) && keep);
  endfunction

endpackage

// File: rtl/req_deglitch.sv
module req_deglitch #(
  parameter int unsigned FILT_CYC = 100,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic raw_n,
  output logic filt_n
);
  import acpi_seq_pkg::*;

  localparam int unsigned CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;

  logic [SYNC_STG-1:0] sync_q;
  logic [CW-1:0]       run_q;
  logic                sync_lvl;
  logic                differs;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STG-2:0], raw_n};
  end

  assign sync_lvl = sync_q[SYNC_STG-1];
  assign differs  = sync_lvl != filt_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      filt_n <= 1'b1;
      run_q  <= '0;
    end else if (!differs) begin
      run_q  <= '0;
    end else if (last_tick(32'(run_q), FILT_CYC)) begin
      filt_n <= sync_lvl;
      run_q  <= '0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  a_r1_follows_sync: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(filt_n) |-> (filt_n == $past(sync_lvl)));

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  output logic done
);
  import acpi_seq_pkg::*;

  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign done = run && last_tick(32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           cnt_q <= '0;
    else if (!run || done) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!por_n)
    32'(cnt_q) < LIMIT);

endmodule

// File: rtl/state_core.sv
module state_core (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    s3f_n,
  input  logic                    s5f_n,
  input  logic                    main_pg,
  input  logic                    shdn_req,
  input  logic                    dual5_keep,
  input  logic                    entry_done,
  input  logic                    wake_done,
  output logic                    entry_run,
  output logic                    wake_run,
  output acpi_seq_pkg::pstate_t   st,
  output logic                    fault,
  output logic                    act_sw_en,
  output logic                    vid_en,
  output logic                    dual5_sb_en,
  output logic                    dual3_sb_en
);
  import acpi_seq_pkg::*;

  pstate_t st_q, st_d;
  logic    fault_q, fault_d;
  logic    forced_q, forced_d;
  logic    both_high;
  logic    main_loss;

  assign both_high = s3f_n && s5f_n;
  assign main_loss = (st_q == PS_ACT) && !main_pg;

  assign entry_run = !shdn_req && !s3f_n &&
                     ((st_q == PS_PEND) || ((st_q == PS_ACT) && main_pg));
  assign wake_run  = !shdn_req && (st_q == PS_PEND) && main_pg && both_high;

  always_comb begin
    st_d     = st_q;
    fault_d  = fault_q;
    forced_d = forced_q;
    if (shdn_req) begin
      st_d     = PS_PEND;
      fault_d  = 1'b0;
      forced_d = 1'b0;
    end else begin
      unique case (st_q)
        PS_PEND: begin
          if (entry_done)     st_d = sleep_target(s5f_n);
          else if (wake_done) st_d = PS_ACT;
        end
        PS_ACT: begin
          if (main_loss) begin
            st_d     = PS_S45;
            fault_d  = 1'b1;
            forced_d = 1'b1;
          end else if (entry_done) begin
            st_d = sleep_target(s5f_n);
          end
        end
        PS_S3: begin
          if (both_high) st_d = PS_PEND;
        end
        PS_S45: begin
          if (forced_q) begin
            if (main_pg) begin
              forced_d = 1'b0;
              fault_d  = 1'b0;
            end
          end else if (both_high) begin
            st_d = PS_PEND;
          end
        end
        default: st_d = PS_PEND;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q     <= PS_PEND;
      fault_q  <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      fault_q  <= fault_d;
      forced_q <= forced_d;
    end
  end

  assign st          = st_q;
  assign fault       = fault_q;
  assign act_sw_en   = !shdn_req && (st_q == PS_ACT);
  assign vid_en      = !shdn_req && (st_q == PS_ACT);
  assign dual5_sb_en = !shdn_req && dual5_on(st_q, dual5_keep);
  assign dual3_sb_en = !shdn_req && (st_q != PS_ACT);

  a_r4_no_s3_to_s45: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PS_S3) |=> (st_q != PS_S45));

  a_r4_no_s45_to_s3: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PS_S45) |=> (st_q != PS_S3));

  a_r5_active_after_wake: assert property (@(posedge clk) disable iff (!por_n)
    $rose(st_q == PS_ACT) |-> $past(wake_done));

  a_r3_sleep_after_entry: assert property (@(posedge clk) disable iff (!por_n)
    ((st_q == PS_S3) || ((st_q == PS_S45) && !fault_q)) &&
    (($past(st_q) == PS_PEND) || ($past(st_q) == PS_ACT)) |-> $past(entry_done));

  a_r8_loss_forces_deep: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PS_ACT) && !main_pg && !shdn_req |=> (st_q == PS_S45) && fault_q);

  a_r8_fault_in_deep: assert property (@(posedge clk) disable iff (!por_n)
    fault_q |-> (st_q == PS_S45));

endmodule

// File: rtl/acpi_sleep_seq.sv
module acpi_sleep_seq #(
  parameter int unsigned FILT_CYC  = 100,
  parameter int unsigned ENTRY_CYC = 10000,
  parameter int unsigned WAKE_CYC  = 1250000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       slp3_n,
  input  logic       slp5_n,
  input  logic       main_pg,
  input  logic       shdn_req,
  input  logic       dual5_keep,
  output logic       act_sw_en,
  output logic       vid_en,
  output logic       dual5_sb_en,
  output logic       dual3_sb_en,
  output logic [1:0] pwr_state,
  output logic       uv_fault
);
  import acpi_seq_pkg::*;

  localparam int unsigned NREQ = 2;

  logic [NREQ-1:0] raw_req;
  logic [NREQ-1:0] filt_req;
  logic            entry_run, entry_done;
  logic            wake_run, wake_done;
  pstate_t         st;

  assign raw_req = {slp5_n, slp3_n};

  for (genvar i = 0; i < NREQ; i++) begin : g_filt
    req_deglitch #(.FILT_CYC(FILT_CYC), .SYNC_STG(2)) u_flt (
      .clk    (clk),
      .por_n  (por_n),
      .raw_n  (raw_req[i]),
      .filt_n (filt_req[i])
    );
  end

  ivl_timer #(.LIMIT(ENTRY_CYC)) u_entry (
    .clk   (clk),
    .por_n (por_n),
    .run   (entry_run),
    .done  (entry_done)
  );

  ivl_timer #(.LIMIT(WAKE_CYC)) u_wake (
    .clk   (clk),
    .por_n (por_n),
    .run   (wake_run),
    .done  (wake_done)
  );

  state_core u_core (
    .clk         (clk),
    .por_n       (por_n),
    .s3f_n       (filt_req[0]),
    .s5f_n       (filt_req[1]),
    .main_pg     (main_pg),
    .shdn_req    (shdn_req),
    .dual5_keep  (dual5_keep),
    .entry_done  (entry_done),
    .wake_done   (wake_done),
    .entry_run   (entry_run),
    .wake_run    (wake_run),
    .st          (st),
    .fault       (uv_fault),
    .act_sw_en   (act_sw_en),
    .vid_en      (vid_en),
    .dual5_sb_en (dual5_sb_en),
    .dual3_sb_en (dual3_sb_en)
  );

  assign pwr_state = st;

endmodule

// File: tb/tb_acpi_sleep_seq.sv
`timescale 1ns/1ps
module tb_acpi_sleep_seq;
  localparam int FILT  = 4;
  localparam int ENTRY = 20;
  localparam int WAKE  = 50;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic slp3_n = 1'b1, slp5_n = 1'b1, main_pg = 1'b0, shdn_req = 1'b0, dual5_keep = 1'b0;
  logic act_sw_en, vid_en, dual5_sb_en, dual3_sb_en, uv_fault;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  acpi_sleep_seq #(.FILT_CYC(FILT), .ENTRY_CYC(ENTRY), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .por_n(por_n), .slp3_n(slp3_n), .slp5_n(slp5_n), .main_pg(main_pg),
    .shdn_req(shdn_req), .dual5_keep(dual5_keep), .act_sw_en(act_sw_en), .vid_en(vid_en),
    .dual5_sb_en(dual5_sb_en), .dual3_sb_en(dual3_sb_en), .pwr_state(pwr_state),
    .uv_fault(uv_fault));

  // Behavioural reference: states 0 pending, 1 active, 2 suspend, 3 deep.
  int m_sa[2], m_sb[2], m_f[2], m_fc[2];
  int m_st, m_fault, m_forced, m_ec, m_wc;
  int n_st, n_fault, n_forced;
  bit erun, wrun, edone, wdone;
  int rawv[2];

  always @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i < 2; i++) begin
        m_sa[i] = 1; m_sb[i] = 1; m_f[i] = 1; m_fc[i] = 0;
      end
      m_st = 0; m_fault = 0; m_forced = 0; m_ec = 0; m_wc = 0;
    end else begin
      erun  = !shdn_req && m_f[0] == 0 && (m_st == 0 || (m_st == 1 && main_pg));
      wrun  = !shdn_req && m_st == 0 && main_pg && m_f[0] == 1 && m_f[1] == 1;
      edone = erun && (m_ec == ENTRY - 1);
      wdone = wrun && (m_wc == WAKE - 1);
      n_st = m_st; n_fault = m_fault; n_forced = m_forced;
      if (shdn_req) begin
        n_st = 0; n_fault = 0; n_forced = 0;
      end else if (m_st == 0) begin
        if (edone) n_st = m_f[1] ? 2 : 3;
        else if (wdone) n_st = 1;
      end else if (m_st == 1) begin
        if (!main_pg) begin n_st = 3; n_fault = 1; n_forced = 1; end
        else if (edone) n_st = m_f[1] ? 2 : 3;
      end else if (m_st == 2) begin
        if (m_f[0] && m_f[1]) n_st = 0;
      end else begin
        if (m_forced) begin
          if (main_pg) begin n_forced = 0; n_fault = 0; end
        end else if (m_f[0] && m_f[1]) n_st = 0;
      end
      m_ec = (erun && !edone) ? m_ec + 1 : 0;
      m_wc = (wrun && !wdone) ? m_wc + 1 : 0;
      m_st = n_st; m_fault = n_fault; m_forced = n_forced;
      rawv[0] = slp3_n; rawv[1] = slp5_n;
      for (int i = 0; i < 2; i++) begin
        if (m_sb[i] == m_f[i]) m_fc[i] = 0;
        else if (m_fc[i] == FILT - 1) begin m_f[i] = m_sb[i]; m_fc[i] = 0; end
        else m_fc[i] = m_fc[i] + 1;
        m_sb[i] = m_sa[i];
        m_sa[i] = rawv[i];
      end
    end
  end

  function automatic logic [6:0] model_out();
    logic act;
    act = !shdn_req && m_st == 1;
    return {2'(m_st), 1'(m_fault), act, act,
            1'(!shdn_req && (m_st == 2 || (m_st == 3 && dual5_keep))),
            1'(!shdn_req && m_st != 1)};
  endfunction

  always @(posedge clk) begin
    #5;
    if (!finished) begin
      checks++;
      if ({pwr_state, uv_fault, act_sw_en, vid_en, dual5_sb_en, dual3_sb_en} !== model_out()) begin
        errors++;
        $display("FAIL per-cycle model (R2/R3/R5/R6/R7/R8) t=%0t actual=%b expected=%b", $time,
                 {pwr_state, uv_fault, act_sw_en, vid_en, dual5_sb_en, dual3_sb_en}, model_out());
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, run hung (R5 sequence)");
      summary();
    end
  end

  initial begin
    cyc(3);
    chk("R10 state in reset", pwr_state, 0);
    chk("R10 act_sw_en in reset", act_sw_en, 0);
    chk("R10 dual3_sb_en in reset", dual3_sb_en, 1);
    chk("R10 uv_fault in reset", uv_fault, 0);
    por_n = 1'b1; main_pg = 1'b1;
    cyc(WAKE - 5);
    chk("R5 still pending before timeout", pwr_state, 0);
    cyc(30);
    chk("R5 active after timeout", pwr_state, 1);
    chk("R6 vid_en in active", vid_en, 1);
    chk("R6 act_sw_en in active", act_sw_en, 1);
    // R1: pulse one cycle shorter than the filter
    slp3_n = 1'b0; cyc(FILT - 1); slp3_n = 1'b1; cyc(40);
    chk("R1 short pulse ignored", pwr_state, 1);
    // R3 cancel
    slp3_n = 1'b0; cyc(12); slp3_n = 1'b1; cyc(40);
    chk("R3 cancelled request keeps active", pwr_state, 1);
    // R2 forbidden pair while active
    slp5_n = 1'b0; cyc(40);
    chk("R2 forbidden pair in active", pwr_state, 1);
    slp5_n = 1'b1; cyc(10);
    // suspend entry
    slp3_n = 1'b0; cyc(40);
    chk("R3 suspend entered", pwr_state, 2);
    chk("R6 vid_en off in suspend", vid_en, 0);
    chk("R7 dual5_sb_en in suspend", dual5_sb_en, 1);
    slp5_n = 1'b0; cyc(40);
    chk("R4 suspend does not go deep", pwr_state, 2);
    slp3_n = 1'b1; cyc(40);
    chk("R2 forbidden pair in suspend", pwr_state, 2);
    slp5_n = 1'b1; cyc(10);
    chk("R5 wake goes to pending", pwr_state, 0);
    cyc(80);
    chk("R5 active again", pwr_state, 1);
    // deep sleep
    slp3_n = 1'b0; slp5_n = 1'b0; cyc(40);
    chk("R3 deep entered", pwr_state, 3);
    chk("R7 dual5_sb_en off in deep without keep", dual5_sb_en, 0);
    chk("R7 dual3_sb_en in deep", dual3_sb_en, 1);
    dual5_keep = 1'b1; cyc(1);
    chk("R7 dual5_sb_en on in deep with keep", dual5_sb_en, 1);
    slp5_n = 1'b1; cyc(40);
    chk("R4 deep does not go suspend", pwr_state, 3);
    slp3_n = 1'b1; cyc(10);
    chk("R5 deep wake to pending", pwr_state, 0);
    chk("R7 dual5_sb_en off in pending", dual5_sb_en, 0);
    cyc(80);
    chk("R5 active from deep", pwr_state, 1);
    // main rail loss
    main_pg = 1'b0; cyc(2);
    chk("R8 forced deep", pwr_state, 3);
    chk("R8 uv_fault set", uv_fault, 1);
    cyc(40);
    chk("R8 forced deep held with lines high", pwr_state, 3);
    main_pg = 1'b1; cyc(2);
    chk("R8 uv_fault cleared on recovery", uv_fault, 0);
    cyc(80);
    chk("R8 active after recovery", pwr_state, 1);
    // shutdown
    main_pg = 1'b0; cyc(5);
    shdn_req = 1'b1; cyc(1);
    chk("R9 state pending on shutdown", pwr_state, 0);
    chk("R9 uv_fault cleared on shutdown", uv_fault, 0);
    chk("R9 dual3_sb_en off on shutdown", dual3_sb_en, 0);
    chk("R9 dual5_sb_en off on shutdown", dual5_sb_en, 0);
    shdn_req = 1'b0; main_pg = 1'b1; cyc(80);
    chk("R9 active after shutdown release", pwr_state, 1);
    // reset in the middle
    por_n = 1'b0; cyc(2);
    chk("R10 state on mid-run reset", pwr_state, 0);
    chk("R10 vid_en on mid-run reset", vid_en, 0);
    por_n = 1'b1; cyc(80);
    chk("R10 active after reset release", pwr_state, 1);
    cyc(2);
    summary();
  end

endmodule